// File: doc/BRIEF.md
# Banked Scratchpad Read Conflict Serializer

This block takes one read request from a group of lanes and turns it into a series of per-bank reads on a banked scratchpad of 32-bit words. Each lane carries an active flag and a word address. The word address selects a bank through its low bits and a row through the remaining bits. In every cycle each bank reads at most one row. Lanes that want the same word get that one read together. Lanes that want different rows of the same bank wait for later cycles. Read data goes back to each lane with a one-cycle valid pulse, and `done` marks the cycle in which the last lane receives its data.

The bank count is a parameter with two intended settings. With 16 banks, the 32 lanes are split into two 16-lane groups. The lower group is served to completion before the upper group starts, and lanes in different groups never compete. With 32 banks, all 32 lanes form one group. The scratchpad read ports are combinational: the block drives a read enable and a row for each bank, and the data for that row comes back on `bankData` within the same cycle.

Top module: `scratch_bank_serializer`

## Requirements
- R1: A word address `a` maps to bank `a mod BANKS` and row `a / BANKS`. In any cycle each bank's enable `bankRe[b]` and row `bankRow[b]` request exactly one row, and a lane served from bank `b` receives the word stored at (bank `b`, row).
- R2: A `start` pulse while `busy` is low captures `laneActive` and `laneAddr`, and `busy` is high after that edge. A `start` while `busy` is high is ignored and leaves the request in flight unchanged.
- R3: All lanes whose data is presented in the same cycle and that share a bank carry the same word address.
- R4: Every pending lane of the current group that reads the chosen word of its bank is served in the same cycle as the other lanes reading that word (broadcast), so a request in which every lane reads one word takes one cycle per group.
- R5: In each bank, the address chosen in a cycle is the one held by the lowest-numbered lane of the current group that is still waiting. Distinct addresses in a bank are therefore served in the order in which they first appear in lane order.
- R6: A served lane sees `laneValid` high for one cycle, exactly one edge after its grant. At that moment `laneData` holds the word at its address. Each active lane is served exactly once, and inactive lanes are never served.
- R7: The request takes as many cycles as the sum, over the groups, of the largest number of distinct addresses that fall into any one bank within that group. `done` is high for one cycle, together with the last valid pulse.
- R8: With 16 banks, lanes 0–15 form group 0 and lanes 16–31 form group 1. Group 0 is served completely before any lane of group 1, and a group with no active lane takes no cycles.
- R9: With 32 banks, all 32 lanes form one group, and bank and row use 5 low address bits and the remaining high bits.
- R10: A request with no active lane raises `done` one edge after the capturing edge, and no `laneValid` is raised.
- R11: After reset, `busy`, `done`, `laneValid` and `bankRe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a new request when idle |
| laneActive | input | LANES | Per-lane request flag |
| laneAddr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low bits |
| bankRe | output | BANKS | Per-bank read enable for this cycle |
| bankRow | output | BANKS*(ADDR_W-log2 BANKS) | Per-bank row being read |
| bankData | input | BANKS*DATA_W | Per-bank combinational read data |
| laneValid | output | LANES | One-cycle per-lane data valid |
| laneData | output | LANES*DATA_W | Per-lane registered read data |
| busy | output | 1 | A request is being served |
| done | output | 1 | Last lanes of the request are presented |

## Verification
The checker's properties assume three things: `bankData` returns the word for the row currently on `bankRow`, `start` is a clean single-cycle pulse, and reset is held across the first edges. The checker keeps its own copy of the active mask and the addresses, captured on the accepted `start`, and reasons only about that copy. The bench models the scratchpad as a pure function of the word address, so every returned word can be predicted. It raises `start` only at falling edges, and it issues the start-while-busy case while both configurations are known to be partway through a long request.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Strobes issued by the sequencing control to the datapath each cycle.
  typedef struct packed {
    logic capture;  // latch a new request
    logic step;     // perform one service cycle
  } sbsStrobe_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       lastStep,
  output sbsStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  logic busyQ;
  logic doneQ;

  always_comb begin
    strobe.capture = start && !busyQ;
    strobe.step    = busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= busyQ && lastStep;
      if (strobe.capture) busyQ <= 1'b1;
      else if (busyQ && lastStep) busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath
  import sbs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sbsStrobe_t                strobe,
  input  logic [LANES-1:0]          laneActive,
  input  logic [LANES*ADDR_W-1:0]   laneAddr,
  input  logic [BANKS*DATA_W-1:0]   bankData,
  output logic [BANKS-1:0]          bankRe,
  output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bankRow,
  output logic [LANES-1:0]          laneValid,
  output logic [LANES*DATA_W-1:0]   laneData,
  output logic                      lastStep
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int GROUPS = LANES / BANKS;

  logic [ADDR_W-1:0] addrQ    [LANES];
  logic [DATA_W-1:0] dataQ    [LANES];
  logic [DATA_W-1:0] bankWord [BANKS];
  logic [ADDR_W-1:0] leadAddr [BANKS];
  logic [LANES-1:0]  pendingQ;
  logic [LANES-1:0]  validQ;
  logic [LANES-1:0]  eligible;
  logic [LANES-1:0]  grant;

  // Only the lowest group that still has pending lanes competes this cycle.
  always_comb begin
    logic hit;
    hit      = 1'b0;
    eligible = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (!hit && (|pendingQ[g*BANKS +: BANKS])) begin
        eligible[g*BANKS +: BANKS] = pendingQ[g*BANKS +: BANKS];
        hit = 1'b1;
      end
    end
  end

  // Per bank: the lowest eligible lane mapping to the bank sets its address.
  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic              found;
    logic [ADDR_W-1:0] lead;
    always_comb begin
      found = 1'b0;
      lead  = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (eligible[l] && (addrQ[l][BANK_W-1:0] == BANK_W'(b))) begin
          found = 1'b1;
          lead  = addrQ[l];
        end
      end
    end
    assign leadAddr[b] = lead;
    assign bankRe[b]   = found;
    assign bankRow[b*ROW_W +: ROW_W] = lead[ADDR_W-1:BANK_W];
    assign bankWord[b] = bankData[b*DATA_W +: DATA_W];
  end

  // Every eligible lane holding its bank's chosen address is served now.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      grant[l] = eligible[l] && (addrQ[l] == leadAddr[addrQ[l][BANK_W-1:0]]);
    end
  end

  assign lastStep = ((pendingQ & ~grant) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= '0;
      validQ   <= '0;
      for (int l = 0; l < LANES; l++) begin
        addrQ[l] <= '0;
        dataQ[l] <= '0;
      end
    end else begin
      validQ <= strobe.step ? grant : '0;
      if (strobe.capture) begin
        pendingQ <= laneActive;
        for (int l = 0; l < LANES; l++) addrQ[l] <= laneAddr[l*ADDR_W +: ADDR_W];
      end else if (strobe.step) begin
        pendingQ <= pendingQ & ~grant;
      end
      for (int l = 0; l < LANES; l++) begin
        if (strobe.step && grant[l]) dataQ[l] <= bankWord[addrQ[l][BANK_W-1:0]];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : gLaneOut
    assign laneData[l*DATA_W +: DATA_W] = dataQ[l];
  end
  assign laneValid = validQ;
endmodule

// File: rtl/scratch_bank_serializer.sv
module scratch_bank_serializer
  import sbs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     start,
  input  logic [LANES-1:0]                         laneActive,
  input  logic [LANES*ADDR_W-1:0]                  laneAddr,
  output logic [BANKS-1:0]                         bankRe,
  output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0]  bankRow,
  input  logic [BANKS*DATA_W-1:0]                  bankData,
  output logic [LANES-1:0]                         laneValid,
  output logic [LANES*DATA_W-1:0]                  laneData,
  output logic                                     busy,
  output logic                                     done
);
  sbsStrobe_t strobe;
  logic       lastStep;

  sbs_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastStep (lastStep),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  sbs_datapath #(
    .LANES  (LANES),
    .BANKS  (BANKS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .laneActive (laneActive),
    .laneAddr   (laneAddr),
    .bankData   (bankData),
    .bankRe     (bankRe),
    .bankRow    (bankRow),
    .laneValid  (laneValid),
    .laneData   (laneData),
    .lastStep   (lastStep)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES  = 32,
  parameter int BANKS  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [LANES-1:0]        laneActive,
  input logic [LANES*ADDR_W-1:0] laneAddr,
  input logic [LANES-1:0]        laneValid,
  input logic                    busy,
  input logic                    done
);
  localparam int BANK_W = $clog2(BANKS);

  logic [LANES-1:0]  capActive;
  logic [LANES-1:0]  servedQ;
  logic [ADDR_W-1:0] capAddr [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capActive <= '0;
      servedQ   <= '0;
      for (int l = 0; l < LANES; l++) capAddr[l] <= '0;
    end else if (start && !busy) begin
      capActive <= laneActive;
      servedQ   <= '0;
      for (int l = 0; l < LANES; l++) capAddr[l] <= laneAddr[l*ADDR_W +: ADDR_W];
    end else begin
      servedQ <= servedQ | laneValid;
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      // R6: served lanes were requested and are served only once
      a_r6_only_active: assert ((laneValid & ~capActive) == '0);
      a_r6_served_once: assert ((laneValid & servedQ) == '0);
      // R7: done means every requested lane has now been served
      if (done) a_r7_done_complete: assert ((servedQ | laneValid) == capActive);
      for (int i = 0; i < LANES; i++) begin
        for (int j = i + 1; j < LANES; j++) begin
          if (laneValid[i] && laneValid[j] &&
              capAddr[i][BANK_W-1:0] == capAddr[j][BANK_W-1:0]) begin
            // R3: one row per bank per cycle
            a_r3_one_row_per_bank: assert (capAddr[i] == capAddr[j]);
          end
        end
        if (laneValid[i]) begin
          for (int k = 0; k < (i / BANKS) * BANKS; k++) begin
            // R8: lower groups finish before a higher group is served
            if (capActive[k]) a_r8_group_order: assert (servedQ[k]);
          end
        end
      end
    end
  end

  // R2: an accepted start makes the block busy
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7: done is a single pulse and nothing is presented after it
  a_r7_done_then_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && laneValid == '0));
endmodule

bind scratch_bank_serializer sbs_checker #(
  .LANES  (LANES),
  .BANKS  (BANKS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (.*);

// File: tb/scratch_bank_serializer_tb.sv
module scratch_bank_serializer_tb_top;
  localparam int LANES  = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int NB     = 16;
  localparam int WB     = 32;
  localparam int NROW   = ADDR_W - 4;
  localparam int WROW   = ADDR_W - 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LANES-1:0]        active = '0;
  logic [LANES*ADDR_W-1:0] addrFlat = '0;

  logic [NB-1:0]             nBankRe;
  logic [NB*NROW-1:0]        nBankRow;
  logic [NB*DATA_W-1:0]      nBankData;
  logic [LANES-1:0]          nValid;
  logic [LANES*DATA_W-1:0]   nData;
  logic                      nBusy, nDone;
  logic [WB-1:0]             wBankRe;
  logic [WB*WROW-1:0]        wBankRow;
  logic [WB*DATA_W-1:0]      wBankData;
  logic [LANES-1:0]          wValid;
  logic [LANES*DATA_W-1:0]   wData;
  logic                      wBusy, wDone;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [ADDR_W-1:0] reqAddr [LANES];
  logic [LANES-1:0]  reqMask;

  always #5 clk = ~clk;

  function automatic logic [DATA_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F0F;
  endfunction

  // Scratchpad models: content is a pure function of the word address (R1).
  always_comb begin
    for (int b = 0; b < NB; b++)
      nBankData[b*DATA_W +: DATA_W] = wordOf({nBankRow[b*NROW +: NROW], 4'(b)});
    for (int b = 0; b < WB; b++)
      wBankData[b*DATA_W +: DATA_W] = wordOf({wBankRow[b*WROW +: WROW], 5'(b)});
  end

  scratch_bank_serializer #(.LANES(LANES), .BANKS(NB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .laneActive(active), .laneAddr(addrFlat),
    .bankRe(nBankRe), .bankRow(nBankRow), .bankData(nBankData),
    .laneValid(nValid), .laneData(nData), .busy(nBusy), .done(nDone));

  scratch_bank_serializer #(.LANES(LANES), .BANKS(WB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dutWide_i (
    .clk(clk), .rstN(rstN), .start(start), .laneActive(active), .laneAddr(addrFlat),
    .bankRe(wBankRe), .bankRow(wBankRow), .bankData(wBankData),
    .laneValid(wValid), .laneData(wData), .busy(wBusy), .done(wDone));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isFirst(input int j, input int lo);
    for (int k = lo; k < j; k++)
      if (reqMask[k] && reqAddr[k] == reqAddr[j]) return 1'b0;
    return 1'b1;
  endfunction

  // Expected presentation index of each lane (index 0 = falling edge after capture).
  function automatic int calc(input int banks, output int when [LANES]);
    int offset;
    offset = 0;
    for (int g = 0; g < LANES / banks; g++) begin
      int maxc;
      maxc = 0;
      for (int l = g * banks; l < (g + 1) * banks; l++) begin
        when[l] = -1;
        if (reqMask[l]) begin
          int first;
          int rank;
          first = l;
          rank = 0;
          for (int j = l - 1; j >= g * banks; j--)
            if (reqMask[j] && reqAddr[j] == reqAddr[l]) first = j;
          for (int j = g * banks; j < first; j++)
            if (reqMask[j] && isFirst(j, g * banks) &&
                (int'(reqAddr[j]) % banks) == (int'(reqAddr[l]) % banks)) rank++;
          when[l] = offset + rank + 1;
          if (rank + 1 > maxc) maxc = rank + 1;
        end
      end
      offset += maxc;
    end
    return offset;
  endfunction

  function automatic void mon(input logic [LANES-1:0] v, input logic [LANES*DATA_W-1:0] d,
                              input logic dn, input int idx, inout int seen [LANES],
                              inout bit ok [LANES], inout int doneAt);
    for (int l = 0; l < LANES; l++) begin
      if (v[l]) begin
        seen[l] = (seen[l] == -1) ? idx : -2;
        ok[l] = (d[l*DATA_W +: DATA_W] == wordOf(reqAddr[l]));
      end
    end
    if (dn) doneAt = (doneAt == -1) ? idx : -2;
  endfunction

  task automatic runReq(input string tag, input bit poke);
    int whenN [LANES];
    int whenW [LANES];
    int seenN [LANES];
    int seenW [LANES];
    bit okN [LANES];
    bit okW [LANES];
    int totN, totW, doneN, doneW, expDn, expDw, last;
    totN = calc(NB, whenN);
    totW = calc(WB, whenW);
    expDn = (totN < 1) ? 1 : totN;
    expDw = (totW < 1) ? 1 : totW;
    last = ((expDn > expDw) ? expDn : expDw) + 2;
    doneN = -1;
    doneW = -1;
    for (int l = 0; l < LANES; l++) begin
      seenN[l] = -1; seenW[l] = -1; okN[l] = 1'b1; okW[l] = 1'b1;
    end
    @(negedge clk);
    active = reqMask;
    for (int l = 0; l < LANES; l++) addrFlat[l*ADDR_W +: ADDR_W] = reqAddr[l];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: both configurations busy right after the capturing edge
    chk(nBusy && wBusy, {"R2 busy ", tag}, int'({nBusy, wBusy}), 3);
    for (int idx = 1; idx <= last; idx++) begin
      if (poke && idx == 2) begin
        start = 1'b1;  // R2: ignored while busy
        active = ~reqMask;
        addrFlat = {LANES{10'h155}};
      end
      if (poke && idx == 3) start = 1'b0;
      @(negedge clk);
      mon(nValid, nData, nDone, idx, seenN, okN, doneN);
      mon(wValid, wData, wDone, idx, seenW, okW, doneW);
    end
    // R7 / R10: request length and done timing, R8 / R9 per configuration
    chk(doneN == expDn, {"R7 R8 done index narrow ", tag}, doneN, expDn);
    chk(doneW == expDw, {"R7 R9 done index wide ", tag}, doneW, expDw);
    for (int l = 0; l < LANES; l++) begin
      // R4 R5 R6: lane served exactly once at the predicted cycle
      chk(seenN[l] == whenN[l], $sformatf("R4 R5 R6 narrow lane %0d %s", l, tag), seenN[l], whenN[l]);
      chk(seenW[l] == whenW[l], $sformatf("R4 R5 R6 wide lane %0d %s", l, tag), seenW[l], whenW[l]);
      // R1 R6: data is the word stored at the lane's address
      if (reqMask[l]) begin
        chk(okN[l], $sformatf("R1 data narrow lane %0d %s", l, tag), int'(okN[l]), 1);
        chk(okW[l], $sformatf("R1 data wide lane %0d %s", l, tag), int'(okW[l]), 1);
      end
    end
    chk(!nBusy && !wBusy, {"R2 idle after ", tag}, int'({nBusy, wBusy}), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int l = 0; l < LANES; l++) reqAddr[l] = '0;
    reqMask = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({nBusy, nDone, wBusy, wDone} == 4'b0, "R11 flags in reset", int'({nBusy, nDone, wBusy, wDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(nValid == '0 && wValid == '0, "R11 no valid after reset", int'(nValid | wValid), 0);
    chk(nBankRe == '0 && wBankRe == '0, "R11 no bank read after reset", int'(wBankRe), 0);
    chk({nBusy, nDone, wBusy, wDone} == 4'b0, "R11 flags after reset", int'({nBusy, nDone, wBusy, wDone}), 0);

    // R10: empty request
    reqMask = '0;
    runReq("R10 empty", 1'b0);

    // R4: broadcast of one word to all lanes
    reqMask = '1;
    for (int l = 0; l < LANES; l++) reqAddr[l] = 10'd77;
    runReq("R4 broadcast", 1'b0);

    // Stride sweep: R5 R7 R8 R9
    for (int s = 0; s <= 33; s++) begin
      reqMask = '1;
      for (int l = 0; l < LANES; l++) reqAddr[l] = ADDR_W'(5 + s * l);
      runReq($sformatf("stride %0d", s), 1'b0);
    end

    // R8: upper group only, and lower group only
    reqMask = 32'hFFFF_0000;
    for (int l = 0; l < LANES; l++) reqAddr[l] = ADDR_W'(l * 16);
    runReq("R8 upper only", 1'b0);
    reqMask = 32'h0000_FFFF;
    runReq("R8 lower only", 1'b0);

    // R2: start while busy is ignored
    reqMask = '1;
    for (int l = 0; l < LANES; l++) reqAddr[l] = ADDR_W'(l * 16);
    runReq("R2 start ignored", 1'b1);

    // Random patterns with narrow address ranges to force repeats
    for (int n = 0; n < 150; n++) begin
      int range;
      range = (n % 3 == 0) ? 8 : ((n % 3 == 1) ? 64 : 1024);
      reqMask = $urandom();
      for (int l = 0; l < LANES; l++) reqAddr[l] = ADDR_W'($urandom_range(range - 1, 0));
      runReq($sformatf("random %0d", n), 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule